// File: doc/BRIEF.md
# Word-Access Serial Port Register Bank

This block is the register face of a simple serial port. A processor reaches it through a single-cycle request port: a valid strobe, a write flag, a byte address and a 32-bit write word. The read word and a 2-bit response code come back one cycle later. There is one byte queue for each direction. A write to the transmit data word puts a byte on the outgoing queue. A read of the receive data word takes the oldest byte off the incoming queue. In both data words, bit 31 carries the queue status.

On the line side, two byte-stream handshakes stand in for the serial wire. The outgoing handshake offers the oldest transmit byte, and only while transmit is switched on. The incoming handshake accepts bytes only while receive is switched on and its queue has room. The interrupt-enable and interrupt-pending words and the clock divisor word are placeholders with fixed read values. Any other access comes back with an error code: a misaligned-address error inside the register window, and an access fault beyond it.

Top module: `serial_word_port`

## Requirements
- R1: After reset both enables are 0, both queues are empty, `bus_rdata` and `bus_err` are 0, `line_tx_valid` is 0 and `line_rx_ready` is 0.
- R2: A write to offset 0x00 appends bits 7:0 of the write word to the transmit queue. When the queue is full at the request, the byte is discarded and the queue is unchanged. Bytes leave in the order they were written.
- R3: A read of offset 0x00 returns 0x8000_0000 when the transmit queue is full and 0 otherwise.
- R4: A read of offset 0x04 removes the oldest receive byte and returns it zero-extended. When the receive queue is empty it returns 0x8000_0000 and removes nothing.
- R5: Offset 0x08 (transmit enable) and offset 0x0C (receive enable) store bit 0 of a write. A read returns that bit in bit 0, with all other bits 0.
- R6: Reads of offset 0x10 and offset 0x14 return 0, and a read of offset 0x18 returns 1. Writes to offsets 0x04, 0x10, 0x14 and 0x18 change nothing.
- R7: `line_tx_valid` is 1 exactly when transmit is enabled and its queue is not empty, and `line_tx_byte` then shows the oldest byte. `line_tx_take` removes that byte only while `line_tx_valid` is 1.
- R8: `line_rx_ready` is 1 exactly when receive is enabled and its queue is not full. A `line_rx_push` while `line_rx_ready` is 0 is discarded.
- R9: `bus_err` is 0 for a good access, 1 for an offset below 0x1C that is not a multiple of 4, and 2 for an offset of 0x1C or more. An erroring access changes no state and returns read data 0.
- R10: `bus_rdata` and `bus_err` reflect the request of the previous cycle. Both are 0 on the cycle after a cycle with no request, and `bus_rdata` is 0 after a write.
- R11: A receive-data read and an accepted line push in the same cycle leave the receive count unchanged and keep arrival order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Request strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the request |
| bus_wdata | input | 32 | Write word |
| bus_rdata | output | 32 | Read word, one cycle after the request |
| bus_err | output | 2 | Response code, one cycle after the request |
| line_tx_valid | output | 1 | An outgoing byte is offered |
| line_tx_byte | output | 8 | Oldest outgoing byte |
| line_tx_take | input | 1 | Line side consumes the offered byte |
| line_rx_ready | output | 1 | Incoming byte can be accepted |
| line_rx_push | input | 1 | Line side delivers a byte |
| line_rx_byte | input | 8 | Delivered byte |

## Verification
The bench fills the transmit queue past capacity while transmit is off, then switches it on and drains it. This separates dropped bytes from gated ones and checks the order of delivery. The bench pushes incoming bytes with receive off, then with receive on until the queue is full, and reads the receive word from both empty and full queues. This shows the difference between an accept, a discard and the empty status word. It also makes a read and a push land in one cycle on each queue. Finally it hits every stub word, misaligned offsets and offsets beyond the window, and compares every cycle's outputs against a queue-based model.

// File: rtl/sreg_pkg.sv
package sreg_pkg;

   localparam int unsigned WORD_W   = 32;
   localparam int unsigned BYTE_W   = 8;
   localparam int unsigned STAT_BIT = 31;
   localparam int unsigned WIN_END  = 'h1C;

   typedef enum logic [1:0] {
      RESP_OK       = 2'd0,
      RESP_MISALIGN = 2'd1,
      RESP_FAULT    = 2'd2
   } resp_e;

   typedef enum logic [2:0] {
      SEL_TXD  = 3'd0,
      SEL_RXD  = 3'd1,
      SEL_TXC  = 3'd2,
      SEL_RXC  = 3'd3,
      SEL_IE   = 3'd4,
      SEL_IP   = 3'd5,
      SEL_DIV  = 3'd6,
      SEL_NONE = 3'd7
   } sel_e;

endpackage

// File: rtl/sreg_decode.sv
module sreg_decode
   import sreg_pkg::*;
#(
   parameter int unsigned ADDR_W = 8
) (
   input  logic [ADDR_W-1:0] addr,
   output sel_e              sel,
   output resp_e             resp
);

   localparam logic [ADDR_W-1:0] LIMIT = ADDR_W'(WIN_END);

   always_comb begin
      sel  = SEL_NONE;
      resp = RESP_OK;
      if (addr >= LIMIT) begin
         resp = RESP_FAULT;
      end else if (addr[1:0] != 2'b00) begin
         resp = RESP_MISALIGN;
      end else begin
         case (addr[4:2])
            3'd0:    sel = SEL_TXD;
            3'd1:    sel = SEL_RXD;
            3'd2:    sel = SEL_TXC;
            3'd3:    sel = SEL_RXC;
            3'd4:    sel = SEL_IE;
            3'd5:    sel = SEL_IP;
            3'd6:    sel = SEL_DIV;
            default: resp = RESP_FAULT;
         endcase
      end
   end

endmodule

// File: rtl/byte_ring.sv
module byte_ring #(
   parameter int unsigned DEPTH  = 2048,
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic [DATA_W-1:0] push_data,
   input  logic              pop,
   output logic [DATA_W-1:0] head_data,
   output logic              empty,
   output logic              full,
   output logic [$clog2(DEPTH+1)-1:0] count
);

   localparam int unsigned PW       = $clog2(DEPTH);
   localparam int unsigned CW       = $clog2(DEPTH+1);
   localparam bit          IS_POW2  = (DEPTH == (1 << PW));

   if (DEPTH < 2) begin : g_depth_bad
      $error("byte_ring: DEPTH must be at least 2");
   end

   logic [DATA_W-1:0] mem [DEPTH];
   logic [PW-1:0]     wr_ptr, rd_ptr, wr_nxt, rd_nxt;

   if (IS_POW2) begin : g_wrap_pow2
      assign wr_nxt = wr_ptr + 1'b1;
      assign rd_nxt = rd_ptr + 1'b1;
   end else begin : g_wrap_mod
      assign wr_nxt = (wr_ptr == PW'(DEPTH-1)) ? '0 : wr_ptr + 1'b1;
      assign rd_nxt = (rd_ptr == PW'(DEPTH-1)) ? '0 : rd_ptr + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (push) begin
         mem[wr_ptr] <= push_data;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (push) wr_ptr <= wr_nxt;
         if (pop)  rd_ptr <= rd_nxt;
         case ({push, pop})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

   assign head_data = mem[rd_ptr];
   assign empty     = (count == '0);
   assign full      = (count == CW'(DEPTH));

endmodule

// File: rtl/serial_word_port.sv
module serial_word_port
   import sreg_pkg::*;
#(
   parameter int unsigned ADDR_W   = 8,
   parameter int unsigned TX_DEPTH = 2048,
   parameter int unsigned RX_DEPTH = 2048
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_valid,
   input  logic              bus_write,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic [1:0]        bus_err,
   output logic              line_tx_valid,
   output logic [7:0]        line_tx_byte,
   input  logic              line_tx_take,
   output logic              line_rx_ready,
   input  logic              line_rx_push,
   input  logic [7:0]        line_rx_byte
);

   localparam int unsigned TXC_W = $clog2(TX_DEPTH+1);
   localparam int unsigned RXC_W = $clog2(RX_DEPTH+1);
   localparam logic [WORD_W-1:0] STATUS_WORD = WORD_W'(1) << STAT_BIT;

   if (ADDR_W < 5) begin : g_addr_bad
      $error("serial_word_port: ADDR_W must cover the register window");
   end

   sel_e  sel;
   resp_e resp;

   sreg_decode #(.ADDR_W(ADDR_W)) u_dec (
      .addr (bus_addr),
      .sel  (sel),
      .resp (resp)
   );

   logic             tx_en, rx_en;
   logic             tx_push, tx_pop, rx_push, rx_pop;
   logic             tx_empty, tx_full, rx_empty, rx_full;
   logic [7:0]       tx_head, rx_head;
   logic [TXC_W-1:0] tx_count;
   logic [RXC_W-1:0] rx_count;

   logic req_ok, req_rd, req_wr;
   assign req_ok = bus_valid && (resp == RESP_OK);
   assign req_rd = req_ok && !bus_write;
   assign req_wr = req_ok && bus_write;

   assign tx_push = req_wr && (sel == SEL_TXD) && !tx_full;
   assign tx_pop  = line_tx_take && line_tx_valid;
   assign rx_pop  = req_rd && (sel == SEL_RXD) && !rx_empty;
   assign rx_push = line_rx_push && line_rx_ready;

   byte_ring #(.DEPTH(TX_DEPTH), .DATA_W(BYTE_W)) u_txq (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (tx_push),
      .push_data (bus_wdata[7:0]),
      .pop       (tx_pop),
      .head_data (tx_head),
      .empty     (tx_empty),
      .full      (tx_full),
      .count     (tx_count)
   );

   byte_ring #(.DEPTH(RX_DEPTH), .DATA_W(BYTE_W)) u_rxq (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (rx_push),
      .push_data (line_rx_byte),
      .pop       (rx_pop),
      .head_data (rx_head),
      .empty     (rx_empty),
      .full      (rx_full),
      .count     (rx_count)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tx_en <= 1'b0;
         rx_en <= 1'b0;
      end else if (req_wr) begin
         if (sel == SEL_TXC) tx_en <= bus_wdata[0];
         if (sel == SEL_RXC) rx_en <= bus_wdata[0];
      end
   end

   logic [WORD_W-1:0] rd_word;
   always_comb begin
      rd_word = '0;
      case (sel)
         SEL_TXD: rd_word = tx_full ? STATUS_WORD : '0;
         SEL_RXD: rd_word = rx_empty ? STATUS_WORD : WORD_W'(rx_head);
         SEL_TXC: rd_word = WORD_W'(tx_en);
         SEL_RXC: rd_word = WORD_W'(rx_en);
         SEL_DIV: rd_word = WORD_W'(1);
         default: rd_word = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bus_rdata <= '0;
         bus_err   <= RESP_OK;
      end else begin
         bus_rdata <= req_rd ? rd_word : '0;
         bus_err   <= bus_valid ? resp : RESP_OK;
      end
   end

   assign line_tx_valid = tx_en && !tx_empty;
   assign line_tx_byte  = tx_head;
   assign line_rx_ready = rx_en && !rx_full;

endmodule

// File: rtl/sreg_checker.sv
module sreg_checker #(
   parameter int unsigned ADDR_W = 8,
   parameter int unsigned TXC_W  = 12,
   parameter int unsigned RXC_W  = 12
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_valid,
   input logic              bus_write,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [31:0]       bus_wdata,
   input logic [31:0]       bus_rdata,
   input logic [1:0]        bus_err,
   input logic              line_tx_valid,
   input logic              line_rx_ready,
   input logic              tx_en,
   input logic              rx_en,
   input logic              tx_push,
   input logic              tx_pop,
   input logic [TXC_W-1:0]  tx_count,
   input logic              rx_push,
   input logic              rx_pop,
   input logic [RXC_W-1:0]  rx_count
);

   p_resp_code_r9: assert property (@(posedge clk) disable iff (!rst_n)
      bus_err != 2'b11);

   p_fault_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && bus_addr >= ADDR_W'(28)) |=> (bus_err == 2'd2 && bus_rdata == 32'd0));

   p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_valid |=> (bus_rdata == 32'd0 && bus_err == 2'd0));

   p_txstat_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && !bus_write && bus_addr == ADDR_W'(0))
      |=> (bus_rdata == 32'd0 || bus_rdata == 32'h8000_0000));

   p_div_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && !bus_write && bus_addr == ADDR_W'(24)) |=> bus_rdata == 32'd1);

   p_ctrl_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && bus_write && bus_addr == ADDR_W'(8)) |=> tx_en == $past(bus_wdata[0]));

   p_tx_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
      line_tx_valid |-> tx_en);

   p_rx_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
      line_rx_ready |-> rx_en);

   p_grow_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_push && !tx_pop) |=> tx_count == TXC_W'($past(tx_count) + 1'b1));

   p_keep_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_push && rx_pop) |=> $stable(rx_count));

endmodule

bind serial_word_port sreg_checker #(
   .ADDR_W (ADDR_W),
   .TXC_W  (TXC_W),
   .RXC_W  (RXC_W)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .bus_valid     (bus_valid),
   .bus_write     (bus_write),
   .bus_addr      (bus_addr),
   .bus_wdata     (bus_wdata),
   .bus_rdata     (bus_rdata),
   .bus_err       (bus_err),
   .line_tx_valid (line_tx_valid),
   .line_rx_ready (line_rx_ready),
   .tx_en         (tx_en),
   .rx_en         (rx_en),
   .tx_push       (tx_push),
   .tx_pop        (tx_pop),
   .tx_count      (tx_count),
   .rx_push       (rx_push),
   .rx_pop        (rx_pop),
   .rx_count      (rx_count)
);

// File: tb/tb_serial_word_port.sv
module tb_serial_word_port;

   localparam int DEPTH = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_valid = 1'b0, bus_write = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [1:0]  bus_err;
   logic        line_tx_valid, line_rx_ready;
   logic [7:0]  line_tx_byte;
   logic        line_tx_take = 1'b0, line_rx_push = 1'b0;
   logic [7:0]  line_rx_byte = '0;

   int n_chk = 0;
   int n_fail = 0;

   always #10 clk = ~clk;

   serial_word_port #(.ADDR_W(8), .TX_DEPTH(DEPTH), .RX_DEPTH(DEPTH)) dut (
      .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .bus_err(bus_err), .line_tx_valid(line_tx_valid), .line_tx_byte(line_tx_byte),
      .line_tx_take(line_tx_take), .line_rx_ready(line_rx_ready),
      .line_rx_push(line_rx_push), .line_rx_byte(line_rx_byte)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   byte q_tx[$];
   byte q_rx[$];
   bit          m_tx_en, m_rx_en;
   logic [31:0] m_rdata;
   logic [1:0]  m_err;

   always @(posedge clk) begin
      if (!rst_n) begin
         q_tx.delete(); q_rx.delete();
         m_tx_en = 0; m_rx_en = 0; m_rdata = 0; m_err = 0;
      end else begin
         automatic int  txn = q_tx.size();
         automatic int  rxn = q_rx.size();
         automatic bit  txe = m_tx_en;
         automatic bit  rxe = m_rx_en;
         automatic int  off = bus_addr;
         m_rdata = 0; m_err = 0;
         if (line_tx_take && txe && txn > 0) void'(q_tx.pop_front());
         if (bus_valid) begin
            if (off >= 28) m_err = 2;
            else if (off % 4 != 0) m_err = 1;
            else if (bus_write) begin
               if (off == 0 && txn < DEPTH) q_tx.push_back(bus_wdata[7:0]);
               if (off == 8)  m_tx_en = bus_wdata[0];
               if (off == 12) m_rx_en = bus_wdata[0];
            end else begin
               case (off)
                  0:  m_rdata = (txn == DEPTH) ? 32'h8000_0000 : 0;
                  4:  m_rdata = (rxn == 0) ? 32'h8000_0000 : {24'd0, q_rx.pop_front()};
                  8:  m_rdata = {31'd0, txe};
                  12: m_rdata = {31'd0, rxe};
                  24: m_rdata = 1;
                  default: m_rdata = 0;
               endcase
            end
         end
         if (line_rx_push && rxe && rxn < DEPTH) q_rx.push_back(line_rx_byte);
      end
   end

   always @(posedge clk) begin
      #5;
      if (rst_n) begin
         check("R10 rdata vs model", bus_rdata, m_rdata);
         check("R9 err vs model", {30'd0, bus_err}, {30'd0, m_err});
         check("R7 tx_valid vs model", {31'd0, line_tx_valid},
               {31'd0, (m_tx_en && q_tx.size() > 0)});
         check("R8 rx_ready vs model", {31'd0, line_rx_ready},
               {31'd0, (m_rx_en && q_rx.size() < DEPTH)});
         if (m_tx_en && q_tx.size() > 0)
            check("R7 tx_byte vs model", {24'd0, line_tx_byte}, {24'd0, q_tx[0]});
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic bus_op(input bit wr, input logic [7:0] a, input logic [31:0] d,
                         output logic [31:0] rd, output logic [1:0] er);
      @(negedge clk);
      bus_valid = 1; bus_write = wr; bus_addr = a; bus_wdata = d;
      @(posedge clk); #5;
      rd = bus_rdata; er = bus_err;
      @(negedge clk);
      bus_valid = 0; bus_write = 0;
   endtask

   task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp_d,
                         input logic [1:0] exp_e, input string tag);
      logic [31:0] d; logic [1:0] e;
      bus_op(0, a, 0, d, e);
      check(tag, d, exp_d);
      check(tag, {30'd0, e}, {30'd0, exp_e});
   endtask

   task automatic wr_chk(input logic [7:0] a, input logic [31:0] v,
                         input logic [1:0] exp_e, input string tag);
      logic [31:0] d; logic [1:0] e;
      bus_op(1, a, v, d, e);
      check(tag, {30'd0, e}, {30'd0, exp_e});
      check(tag, d, 32'd0);
   endtask

   task automatic rx_in(input logic [7:0] b);
      @(negedge clk); line_rx_push = 1; line_rx_byte = b;
      @(negedge clk); line_rx_push = 0;
   endtask

   task automatic take_one();
      @(negedge clk); line_tx_take = 1;
      @(negedge clk); line_tx_take = 0;
   endtask

   // ---------------- directed sequence ----------------
   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(posedge clk); #5;
      check("R1 rdata after reset", bus_rdata, 0);
      check("R1 err after reset", {30'd0, bus_err}, 0);
      check("R1 tx_valid after reset", {31'd0, line_tx_valid}, 0);
      check("R1 rx_ready after reset", {31'd0, line_rx_ready}, 0);
      rd_chk(8'h08, 0, 0, "R1 tx enable reset");
      rd_chk(8'h04, 32'h8000_0000, 0, "R4 empty rx status");

      // fill tx while disabled, one byte past capacity
      for (int i = 0; i < DEPTH; i++) wr_chk(8'h00, 32'hABCD_0010 + i, 0, "R2 tx push");
      check("R7 gated while disabled", {31'd0, line_tx_valid}, 0);
      rd_chk(8'h00, 32'h8000_0000, 0, "R3 tx full status");
      wr_chk(8'h00, 32'h99, 0, "R2 push into full");

      wr_chk(8'h08, 32'hFFFF_FFFF, 0, "R5 tx enable write");
      rd_chk(8'h08, 1, 0, "R5 tx enable readback");
      for (int i = 0; i < DEPTH; i++) begin
         check("R7 offer while enabled", {31'd0, line_tx_valid}, 1);
         check("R2 order, no dropped byte", {24'd0, line_tx_byte}, 32'h10 + i);
         take_one();
      end
      check("R7 drained", {31'd0, line_tx_valid}, 0);
      rd_chk(8'h00, 0, 0, "R3 tx not full");

      // receive disabled
      rx_in(8'h55);
      rd_chk(8'h04, 32'h8000_0000, 0, "R8 push ignored while disabled");
      wr_chk(8'h0C, 32'h0000_0003, 0, "R5 rx enable write");
      rd_chk(8'h0C, 1, 0, "R5 rx enable readback");
      rx_in(8'h41); rx_in(8'hC2);
      rd_chk(8'h04, 32'h41, 0, "R4 pop first");
      rd_chk(8'h04, 32'hC2, 0, "R4 pop zero-extended");
      rd_chk(8'h04, 32'h8000_0000, 0, "R4 empty after drain");

      // fill rx, then overflow
      for (int i = 0; i < DEPTH; i++) rx_in(8'h60 + i);
      check("R8 not ready when full", {31'd0, line_rx_ready}, 0);
      rx_in(8'hEE);
      rd_chk(8'h04, 32'h60, 0, "R8 oldest kept after overflow");
      // simultaneous pop and push
      @(negedge clk);
      bus_valid = 1; bus_write = 0; bus_addr = 8'h04; line_rx_push = 1; line_rx_byte = 8'h70;
      @(posedge clk); #5;
      check("R11 pop during push", bus_rdata, 32'h61);
      @(negedge clk);
      bus_valid = 0; line_rx_push = 0;
      check("R11 count kept (ready)", {31'd0, line_rx_ready}, 1);
      for (int i = 2; i < DEPTH; i++) rd_chk(8'h04, 32'h60 + i, 0, "R11 order kept");
      rd_chk(8'h04, 32'h70, 0, "R11 pushed byte last");
      rd_chk(8'h04, 32'h8000_0000, 0, "R11 empty after");

      // stub words and ignored writes
      wr_chk(8'h10, 32'hFFFF_FFFF, 0, "R6 write IE");
      wr_chk(8'h14, 32'hFFFF_FFFF, 0, "R6 write IP");
      wr_chk(8'h18, 32'h5, 0, "R6 write DIV");
      wr_chk(8'h04, 32'h33, 0, "R6 write RXDATA");
      rd_chk(8'h10, 0, 0, "R6 IE reads 0");
      rd_chk(8'h14, 0, 0, "R6 IP reads 0");
      rd_chk(8'h18, 1, 0, "R6 DIV reads 1");
      rd_chk(8'h04, 32'h8000_0000, 0, "R6 RXDATA write ignored");

      // error responses
      rd_chk(8'h02, 0, 1, "R9 misaligned read");
      wr_chk(8'h01, 32'h77, 1, "R9 misaligned write");
      wr_chk(8'h09, 32'h0, 1, "R9 misaligned ctrl write");
      rd_chk(8'h08, 1, 0, "R9 ctrl untouched by bad write");
      check("R9 no tx push by bad write", {31'd0, line_tx_valid}, 0);
      rd_chk(8'h1C, 0, 2, "R9 fault at window end");
      wr_chk(8'hFC, 32'h1, 2, "R9 fault high");
      @(posedge clk); #5;
      check("R10 idle response rdata", bus_rdata, 0);
      check("R10 idle response err", {30'd0, bus_err}, 0);

      // tx push and line take in one cycle
      wr_chk(8'h00, 32'h31, 0, "R2 tx push");
      wr_chk(8'h00, 32'h32, 0, "R2 tx push");
      @(negedge clk);
      bus_valid = 1; bus_write = 1; bus_addr = 8'h00; bus_wdata = 32'h33; line_tx_take = 1;
      @(negedge clk);
      bus_valid = 0; bus_write = 0; line_tx_take = 0;
      check("R7 head after concurrent take", {24'd0, line_tx_byte}, 32'h32);
      take_one();
      check("R2 concurrent push kept", {24'd0, line_tx_byte}, 32'h33);
      take_one();
      check("R7 empty at end", {31'd0, line_tx_valid}, 0);

      repeat (2) @(negedge clk);
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

   initial begin
      #(20 * 200000);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

endmodule